// File: doc/BRIEF.md
# MSI Page Table Entry Address Generator

This block takes the guest-physical target address of an incoming message-signalled interrupt and works out where the matching 16-byte entry of the MSI page table sits in physical memory. A configurable address mask picks scattered bits out of the target's page number, above bit 12. Those bits are packed into a dense interrupt-file index. The entry address is then formed by OR-ing the table base, which is the configured page number shifted left by 12, with the index shifted left by 4.

The number of mask bits set, k, gives the table size as 2^k entries. The block checks the table base against the alignment that size demands and raises a flag when the base falls short. A request is taken in through a valid/ready pair. The gather runs one mask bit per clock. When the result registers load, a single-cycle done pulse marks them.

Top module: `msi_pte_addr_gen`

## Requirements
- R1: While reset (rstN low, sampled on the clock edge) is applied and after it is released, reqReady is 1, done is 0, pteAddr is 0 and misaligned is 0.
- R2: A request is accepted on a rising edge where reqValid and reqReady are both 1. reqReady stays 0 from that edge until the result is issued. reqValid and request fields presented while reqReady is 0 have no effect on the result.
- R3: The index takes the bits of the target address page number (reqAddr bit 12+i) at every position i where reqMask bit i is 1. They are packed from index bit 0 upward in ascending order of i. Mask positions holding 0 contribute nothing.
- R4: pteAddr equals (reqPpn << 12) bitwise-OR (index << 4), never their sum.
- R5: Entry offsets of 4 KiB or more (index of 256 or above) appear in pteAddr in full, without truncation.
- R6: When the mask has 8 or fewer ones, misaligned is 0 whatever the value of reqPpn.
- R7: When the mask has k > 8 ones, misaligned is 1 exactly when any of the low k-8 bits of reqPpn is 1. Bits beyond the width of reqPpn count as 0.
- R8: done is 1 for exactly one cycle. It becomes visible MASK_W+1 rising edges after the accepting edge, together with the new pteAddr and misaligned. reqReady returns to 1 in that same cycle, and the results hold until the next done.
- R9: An all-zero mask gives index 0 and pteAddr equal to the table base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and able to accept a request |
| reqAddr | input | ADDR_W | Guest-physical MSI target address |
| reqMask | input | MASK_W | Address mask over page-number bits (bit i selects address bit 12+i) |
| reqPpn | input | PPN_W | Page number of the MSI page table base |
| done | output | 1 | One-cycle strobe: results updated |
| pteAddr | output | ADDR_W | Physical address of the selected table entry |
| misaligned | output | 1 | Table base fails the alignment rule for 2^k entries |

## Verification
All results are due in one cycle: the cycle after rising edge MASK_W+1, counted from the accepting edge. In that cycle done, the returned reqReady, pteAddr and misaligned all appear together. The bench counts edges from acceptance and samples on each falling edge. It expects done low and reqReady low, with the previous results unchanged, for every earlier edge. It expects done, reqReady and the new results exactly at edge MASK_W+1, and done low again one edge later. While the block is busy, the bench holds reqValid high with unrelated fields, so that any wrongly accepted data shows up in the next result.

// File: rtl/msi_pte_pkg.sv
package msi_pte_pkg;

  localparam int PAGE_SHIFT = 12;
  localparam int PTE_SHIFT = 4;
  localparam int SMALL_TABLE_LOG2 = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } ctrl_state_t;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } ctrl_strobe_t;

endpackage

// File: rtl/msi_pte_ctrl.sv
module msi_pte_ctrl
  import msi_pte_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         lastBit,
  output logic         reqReady,
  output logic         done,
  output ctrl_strobe_t strobe
);

  ctrl_state_t stateQ;
  logic doneQ;

  always_comb begin
    strobe        = '0;
    strobe.load   = (stateQ == ST_IDLE) && reqValid;
    strobe.step   = (stateQ == ST_RUN);
    strobe.finish = (stateQ == ST_FIN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= strobe.finish;
      case (stateQ)
        ST_IDLE: if (strobe.load) stateQ <= ST_RUN;
        ST_RUN:  if (lastBit)     stateQ <= ST_FIN;
        ST_FIN:                   stateQ <= ST_IDLE;
        default:                  stateQ <= ST_IDLE;
      endcase
    end
  end

  assign reqReady = (stateQ == ST_IDLE);
  assign done     = doneQ;

endmodule

// File: rtl/msi_pte_dp.sv
module msi_pte_dp
  import msi_pte_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int MASK_W = 52,
  parameter int PPN_W  = 44
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [MASK_W-1:0] reqMask,
  input  logic [PPN_W-1:0]  reqPpn,
  output logic              lastBit,
  output logic [ADDR_W-1:0] pteAddr,
  output logic              misaligned
);

  localparam int CNT_W = $clog2(MASK_W + 1);

  logic [MASK_W-1:0] pageQ;
  logic [MASK_W-1:0] maskQ;
  logic [PPN_W-1:0]  ppnQ;
  logic [MASK_W-1:0] idxQ;
  logic [CNT_W-1:0]  bitPosQ;
  logic [CNT_W-1:0]  outPosQ;
  logic [ADDR_W-1:0] pteAddrQ;
  logic              misQ;

  logic [ADDR_W-1:0] tableBase;
  logic [ADDR_W-1:0] entryOffset;
  logic [PPN_W-1:0]  alignMask;

  assign lastBit     = (bitPosQ == CNT_W'(MASK_W - 1));
  assign tableBase   = ADDR_W'(ppnQ) << PAGE_SHIFT;
  assign entryOffset = ADDR_W'(idxQ) << PTE_SHIFT;

  // Once every mask bit is scanned, outPosQ holds the number of ones (k).
  // Tables above 2^8 entries need the low k-8 page-number bits clear.
  always_comb begin
    for (int i = 0; i < PPN_W; i++) begin
      alignMask[i] = (int'(outPosQ) > SMALL_TABLE_LOG2) &&
                     (i < int'(outPosQ) - SMALL_TABLE_LOG2);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageQ    <= '0;
      maskQ    <= '0;
      ppnQ     <= '0;
      idxQ     <= '0;
      bitPosQ  <= '0;
      outPosQ  <= '0;
      pteAddrQ <= '0;
      misQ     <= 1'b0;
    end else begin
      if (strobe.load) begin
        pageQ   <= reqAddr[PAGE_SHIFT +: MASK_W];
        maskQ   <= reqMask;
        ppnQ    <= reqPpn;
        idxQ    <= '0;
        bitPosQ <= '0;
        outPosQ <= '0;
      end
      if (strobe.step) begin
        if (maskQ[bitPosQ]) begin
          idxQ[outPosQ] <= pageQ[bitPosQ];
          outPosQ       <= outPosQ + 1'b1;
        end
        bitPosQ <= bitPosQ + 1'b1;
      end
      if (strobe.finish) begin
        pteAddrQ <= tableBase | entryOffset;
        misQ     <= |(ppnQ & alignMask);
      end
    end
  end

  assign pteAddr    = pteAddrQ;
  assign misaligned = misQ;

endmodule

// File: rtl/msi_pte_addr_gen.sv
module msi_pte_addr_gen
  import msi_pte_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int MASK_W = 52,
  parameter int PPN_W  = 44
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [MASK_W-1:0] reqMask,
  input  logic [PPN_W-1:0]  reqPpn,
  output logic              done,
  output logic [ADDR_W-1:0] pteAddr,
  output logic              misaligned
);

  ctrl_strobe_t strobe;
  logic         lastBit;

  msi_pte_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .lastBit  (lastBit),
    .reqReady (reqReady),
    .done     (done),
    .strobe   (strobe)
  );

  msi_pte_dp #(
    .ADDR_W (ADDR_W),
    .MASK_W (MASK_W),
    .PPN_W  (PPN_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqMask    (reqMask),
    .reqPpn     (reqPpn),
    .lastBit    (lastBit),
    .pteAddr    (pteAddr),
    .misaligned (misaligned)
  );

endmodule

// File: rtl/msi_pte_addr_gen_sva.sv
module msi_pte_addr_gen_sva #(
  parameter int ADDR_W = 64,
  parameter int MASK_W = 52
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [MASK_W-1:0] reqMask,
  input logic              done,
  input logic [ADDR_W-1:0] pteAddr,
  input logic              misaligned
);

  localparam int CNT_W = $clog2(MASK_W + 2) + 1;

  logic [CNT_W-1:0] sinceAccept;
  logic [CNT_W-1:0] onesQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceAccept <= '0;
      onesQ       <= '0;
    end else if (reqValid && reqReady) begin
      sinceAccept <= '0;
      onesQ       <= CNT_W'($countones(reqMask));
    end else if (sinceAccept != {CNT_W{1'b1}}) begin
      sinceAccept <= sinceAccept + 1'b1;
    end
  end

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (sinceAccept == CNT_W'(MASK_W + 1)));

  p_ready_with_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqReady) |-> done);

  p_hold_results_r8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(pteAddr) && $stable(misaligned)));

  p_entry_aligned_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pteAddr[3:0] == 4'h0));

  p_small_table_r6: assert property (@(posedge clk) disable iff (!rstN)
    (done && (onesQ <= CNT_W'(8))) |-> !misaligned);

endmodule

bind msi_pte_addr_gen msi_pte_addr_gen_sva #(
  .ADDR_W (ADDR_W),
  .MASK_W (MASK_W)
) u_sva (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqMask    (reqMask),
  .done       (done),
  .pteAddr    (pteAddr),
  .misaligned (misaligned)
);

// File: tb/msi_pte_addr_gen_bench.sv
`timescale 1ns/1ps
module msi_pte_addr_gen_bench;

  localparam int ADDR_W = 64;
  localparam int MASK_W = 52;
  localparam int PPN_W  = 44;
  localparam int LAT    = MASK_W + 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [MASK_W-1:0] reqMask = '0;
  logic [PPN_W-1:0]  reqPpn = '0;
  logic              done;
  logic [ADDR_W-1:0] pteAddr;
  logic              misaligned;

  int testsRun = 0;
  int testsFailed = 0;
  logic [ADDR_W-1:0] prevAddr = '0;
  logic              prevMis = 1'b0;

  always #5 clk = ~clk;

  msi_pte_addr_gen #(.ADDR_W(ADDR_W), .MASK_W(MASK_W), .PPN_W(PPN_W)) u_msi_pte_addr_gen (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqMask(reqMask), .reqPpn(reqPpn),
    .done(done), .pteAddr(pteAddr), .misaligned(misaligned)
  );

  function automatic logic [MASK_W-1:0] gatherIdx(logic [ADDR_W-1:0] a, logic [MASK_W-1:0] m);
    logic [MASK_W-1:0] r = '0;
    int o = 0;
    for (int i = 0; i < MASK_W; i++) begin
      if (m[i]) begin
        r[o] = a[12 + i];
        o++;
      end
    end
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] expAddr(logic [ADDR_W-1:0] a, logic [MASK_W-1:0] m,
                                                 logic [PPN_W-1:0] p);
    return (ADDR_W'(p) << 12) | (ADDR_W'(gatherIdx(a, m)) << 4);
  endfunction

  function automatic logic expMis(logic [MASK_W-1:0] m, logic [PPN_W-1:0] p);
    int k = $countones(m);
    logic r = 1'b0;
    if (k > 8) begin
      for (int i = 0; i < k - 8; i++) begin
        if (i < PPN_W && p[i]) r = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [ADDR_W-1:0] act,
                       input logic [ADDR_W-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One complete request; while busy, reqValid stays high with unrelated fields (R2).
  task automatic runReq(input logic [ADDR_W-1:0] a, input logic [MASK_W-1:0] m,
                        input logic [PPN_W-1:0] p, input string tag);
    logic [ADDR_W-1:0] ea;
    logic em;
    logic busyOk = 1'b1;
    ea = expAddr(a, m, p);
    em = expMis(m, p);
    @(negedge clk);
    check("R2 ready before request", ADDR_W'(reqReady), 64'd1);
    reqValid = 1'b1;
    reqAddr  = a;
    reqMask  = m;
    reqPpn   = p;
    @(posedge clk);
    for (int j = 0; j <= LAT; j++) begin
      @(negedge clk);
      if (j < 6) begin
        reqValid = 1'b1;
        reqAddr  = ~a;
        reqMask  = ~m;
        reqPpn   = ~p;
      end else begin
        reqValid = 1'b0;
      end
      if (j < LAT) begin
        if (done !== 1'b0 || reqReady !== 1'b0 || pteAddr !== prevAddr || misaligned !== prevMis)
          busyOk = 1'b0;
      end
    end
    reqValid = 1'b0;
    check("R8 busy window: done low, ready low, results held", ADDR_W'(busyOk), 64'd1);
    check("R8 done at edge MASK_W+1", ADDR_W'(done), 64'd1);
    check("R8 ready back with done", ADDR_W'(reqReady), 64'd1);
    check({tag, " address"}, pteAddr, ea);
    check({tag, " misaligned"}, ADDR_W'(misaligned), ADDR_W'(em));
    prevAddr = pteAddr;
    prevMis  = misaligned;
    @(negedge clk);
    check("R8 done one cycle only", ADDR_W'(done), 64'd0);
    check("R8 results hold after done", pteAddr, prevAddr);
  endtask

  function automatic logic [MASK_W-1:0] nBits(int n, int start, int stride);
    logic [MASK_W-1:0] r = '0;
    for (int i = 0; i < n; i++) r[(start + i * stride) % MASK_W] = 1'b1;
    return r;
  endfunction

  initial begin
    void'($urandom(32'h1d5e_7a11));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 ready in reset", ADDR_W'(reqReady), 64'd1);
    check("R1 done in reset", ADDR_W'(done), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 address after reset", pteAddr, 64'd0);
    check("R1 misaligned after reset", ADDR_W'(misaligned), 64'd0);
    check("R1 ready after reset", ADDR_W'(reqReady), 64'd1);
    // reqValid low for a while: nothing must start
    repeat (4) @(negedge clk);
    check("R2 idle without request", ADDR_W'(done) | ADDR_W'(!reqReady), 64'd0);

    // Directed corners
    runReq(64'hFFFF_FFFF_FFFF_F123, '0, 44'h0AB_CDEF_1234, "R9 zero mask");
    runReq(64'h0000_0000_0055_5000, nBits(8, 0, 1), 44'h123_4567_89AB, "R6 k=8 odd base");
    runReq(64'h0000_0000_0010_0000, nBits(9, 0, 1), 44'h1, "R7 R4 R5 k=9 base bit0 OR not add");
    runReq(64'h0000_0000_1FF0_0000, nBits(9, 0, 1), 44'h2, "R7 k=9 base bit1 aligned");
    runReq(64'h0000_0000_ABCD_E000, nBits(12, 3, 4), 44'h0F0, "R3 R7 k=12 scattered");
    runReq(64'hDEAD_BEEF_CAFE_F000, '1, 44'h0, "R5 R7 full mask aligned");
    runReq(64'h1234_5678_9ABC_D000, '1, 44'h800_0000_0000, "R7 full mask top ppn bit");
    runReq(64'h0000_0000_0000_A000, 52'h8_0000_0000_0005, 44'h777, "R3 R6 sparse high bit");

    // Random requests
    for (int t = 0; t < 40; t++) begin
      logic [ADDR_W-1:0] a;
      logic [MASK_W-1:0] m;
      logic [PPN_W-1:0]  p;
      int clr;
      a = {$urandom, $urandom};
      m = MASK_W'({$urandom, $urandom});
      case (t % 4)
        0: m = m & MASK_W'({$urandom, $urandom}) & MASK_W'({$urandom, $urandom});
        1: m = nBits(int'($urandom_range(0, 14)), int'($urandom_range(0, 51)),
                     int'($urandom_range(1, 3)));
        default: ;
      endcase
      p = PPN_W'({$urandom, $urandom});
      clr = int'($urandom_range(0, 45));
      if (t % 2 == 0) begin
        for (int i = 0; i < PPN_W; i++) if (i < clr) p[i] = 1'b0;
      end
      runReq(a, m, p, "R3 R4 R7 random");
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule